// File: doc/BRIEF.md
# Flat-Panel Power Sequencer

This block steps a flat panel through a timed power-on and power-off order. It drives two outputs, a supply enable for the panel electronics and an enable for the backlight. On the way up the supply comes on first and the backlight follows. On the way down the backlight goes off first and the supply follows. After every power-down the block holds the panel off for a minimum time before a new power-up can begin.

Software reaches the block through a small synchronous register port with a 32-bit data path. The port holds a control word, two delay words, a cycle-delay code and a read-only status word. The four edge delays count in 100 µs steps. A prescaler sized by a parameter produces those steps from the input clock, and a second counter builds 100 ms units from them for the minimum off time. The control word changes only when a write carries the unlock key. The status word reports whether the panel is fully on, which way a sequence is moving, and whether the minimum off time is still running.

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset, `vdd_en` and `bl_en` are 0 and the status word reads 0. The on-delay word reads 0x0834_01F4 (210 ms / 50 ms). The off-delay word reads 0x1388_01F4 (500 ms / 50 ms). The cycle code reads 7. The control word reads 0.
- R2: A write to the control word (offset 0) takes effect only when data bits 31:16 equal 0xABCD. Otherwise all four control bits stay unchanged. Bit 0 requests power-on, bit 1 is a stored power-down-on-reset flag, bit 2 requests backlight and bit 3 forces the supply on. A read returns these four bits in place and zeros elsewhere.
- R3: The on-delay word (offset 2) holds the power-up delay in bits 28:16 and the supply-to-backlight delay in bits 12:0. The off-delay word (offset 3) holds the supply-off delay in bits 28:16 and the backlight-to-supply delay in bits 12:0. The cycle code sits at offset 4, bits 4:0. Other bits read 0.
- R4: When power-on is requested from idle, `vdd_en` rises one cycle after the write. The block then waits the power-up delay and the supply-to-backlight delay, each a count of 100 µs ticks, before the panel counts as fully on.
- R5: `bl_en` is 1 only while the panel is fully on and control bit 2 is set. Clearing bit 2 drops `bl_en` without touching `vdd_en`.
- R6: When the power-on request is cleared while fully on, `bl_en` drops first. `vdd_en` drops after the backlight-to-supply delay. The sequence then stays busy for the supply-off delay.
- R7: Status bits 29:28 read 01 during power-up, 10 during power-down and 00 otherwise. Bit 31 is 1 only while fully on. Bit 27 is 1 while the minimum off time runs.
- R8: After a power-down, the minimum off time lasts (code−1)×100 ms, or zero when the code is 0 or 1. A power-on request made during that time is held until it ends.
- R9: Clearing the power-on request during power-up aborts it. `vdd_en` drops in the next cycle, the status reports power-down, and the off sequence continues.
- R10: Control bit 3 forces `vdd_en` to 1 at once, with `bl_en` at 0 and the status idle. Clearing it drops `vdd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| vdd_en | output | 1 | Panel supply enable |
| bl_en | output | 1 | Backlight enable |

## Verification
The assertions check on every cycle the rules that involve no elapsed time:
- the backlight is never enabled without the supply;
- the backlight is off in the cycle before the sequenced supply falls;
- a keyless control write leaves the control bits alone;
- an abort goes straight to power-down;
- the sequencer never leaves the minimum off time before its timer expires;
- the delay counter only holds or steps down by one.

Only the bench scenarios can show that each delay lasts the programmed number of ticks, that the reset values and field positions are right, that a cycle code of 1 removes the off time, and that the override acts without a sequence.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PWR_UP, ST_BL_WAIT, ST_ON, ST_BL_OFF, ST_PWR_DN, ST_CYCLE
  } seq_state_e;

  localparam logic [15:0] UNLOCK_KEY = 16'hABCD;
  localparam int DLY_W = 13;
  localparam int CYC_W = 5;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_STAT   = 3'd1;
  localparam logic [2:0] A_ONDLY  = 3'd2;
  localparam logic [2:0] A_OFFDLY = 3'd3;
  localparam logic [2:0] A_CYC    = 3'd4;

  localparam logic [DLY_W-1:0] RST_UP    = 13'd2100;
  localparam logic [DLY_W-1:0] RST_BLON  = 13'd500;
  localparam logic [DLY_W-1:0] RST_DN    = 13'd5000;
  localparam logic [DLY_W-1:0] RST_BLOFF = 13'd500;
  localparam logic [CYC_W-1:0] RST_CYC   = 5'd7;
endpackage

// File: rtl/pps_timer.sv
module pps_timer #(
  parameter int TICK_CLKS  = 10000,
  parameter int LONG_TICKS = 1000,
  parameter int CNT_W      = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             long_unit,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  localparam int PRE_W = $clog2(TICK_CLKS + 1);
  localparam int LNG_W = $clog2(LONG_TICKS + 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [LNG_W-1:0] lng_q, lng_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             unit_q, unit_d;
  logic             tick, lwrap, step;

  assign tick    = (pre_q == PRE_W'(TICK_CLKS - 1));
  assign lwrap   = tick && (lng_q == LNG_W'(LONG_TICKS - 1));
  assign step    = unit_q ? lwrap : tick;
  assign expired = (cnt_q == '0);

  always_comb begin
    pre_d  = tick ? '0 : pre_q + 1'b1;
    lng_d  = tick ? (lwrap ? '0 : lng_q + 1'b1) : lng_q;
    cnt_d  = (step && !expired) ? cnt_q - 1'b1 : cnt_q;
    unit_d = unit_q;
    if (load) begin
      pre_d  = '0;
      lng_d  = '0;
      cnt_d  = load_val;
      unit_d = long_unit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      lng_q  <= '0;
      cnt_q  <= '0;
      unit_q <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      lng_q  <= lng_d;
      cnt_q  <= cnt_d;
      unit_q <= unit_d;
    end
  end

  // R4: between loads the remaining count only holds or steps down by one
  p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pps_regs.sv
module pps_regs
  import pps_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  input  logic [31:0]      stat_word,
  output logic [31:0]      bus_rdata,
  output logic             on_req,
  output logic             bl_req,
  output logic             vdd_ovr,
  output logic [DLY_W-1:0] dly_up,
  output logic [DLY_W-1:0] dly_blon,
  output logic [DLY_W-1:0] dly_dn,
  output logic [DLY_W-1:0] dly_bloff,
  output logic [CYC_W-1:0] cyc_code
);
  logic [3:0] ctrl_q;
  logic [DLY_W-1:0] up_q, blon_q, dn_q, bloff_q;
  logic [CYC_W-1:0] cyc_q;
  logic wr_any, wr_ctrl, wr_on, wr_off, wr_cyc;
  logic unused_bits;

  assign wr_any  = bus_sel && bus_wr;
  assign wr_ctrl = wr_any && (bus_addr == A_CTRL) && (bus_wdata[31:16] == UNLOCK_KEY);
  assign wr_on   = wr_any && (bus_addr == A_ONDLY);
  assign wr_off  = wr_any && (bus_addr == A_OFFDLY);
  assign wr_cyc  = wr_any && (bus_addr == A_CYC);
  assign unused_bits = ^{bus_wdata[15:13], bus_wdata[31:29], bus_wdata[12:5]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      up_q    <= RST_UP;
      blon_q  <= RST_BLON;
      dn_q    <= RST_DN;
      bloff_q <= RST_BLOFF;
      cyc_q   <= RST_CYC;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[3:0];
      if (wr_on) begin
        up_q   <= bus_wdata[28:16];
        blon_q <= bus_wdata[12:0];
      end
      if (wr_off) begin
        dn_q    <= bus_wdata[28:16];
        bloff_q <= bus_wdata[12:0];
      end
      if (wr_cyc) cyc_q <= bus_wdata[4:0];
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:   bus_rdata = {28'd0, ctrl_q};
      A_STAT:   bus_rdata = stat_word;
      A_ONDLY:  bus_rdata = {3'd0, up_q, 3'd0, blon_q};
      A_OFFDLY: bus_rdata = {3'd0, dn_q, 3'd0, bloff_q};
      A_CYC:    bus_rdata = {27'd0, cyc_q};
      default:  bus_rdata = '0;
    endcase
  end

  assign on_req    = ctrl_q[0];
  assign bl_req    = ctrl_q[2];
  assign vdd_ovr   = ctrl_q[3];
  assign dly_up    = up_q;
  assign dly_blon  = blon_q;
  assign dly_dn    = dn_q;
  assign dly_bloff = bloff_q;
  assign cyc_code  = cyc_q;

  // R2: a control write without the key leaves every control bit alone
  p_key_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == A_CTRL && bus_wdata[31:16] != UNLOCK_KEY)
      |=> $stable(ctrl_q));
endmodule

// File: rtl/pps_fsm.sv
module pps_fsm
  import pps_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             want_on,
  input  logic [DLY_W-1:0] dly_up,
  input  logic [DLY_W-1:0] dly_blon,
  input  logic [DLY_W-1:0] dly_dn,
  input  logic [DLY_W-1:0] dly_bloff,
  input  logic [CYC_W-1:0] cyc_code,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic             tmr_long,
  output logic [DLY_W-1:0] tmr_val,
  output logic             seq_vdd,
  output logic             full_on,
  output logic [1:0]       progress,
  output logic             cyc_active
);
  seq_state_e state_q, state_d;
  logic [DLY_W-1:0] cyc_units;

  assign cyc_units = (cyc_code > 5'd1) ? DLY_W'(cyc_code - 5'd1) : '0;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (want_on) state_d = ST_PWR_UP;
      ST_PWR_UP:  if (!want_on) state_d = ST_PWR_DN;
                  else if (tmr_expired) state_d = ST_BL_WAIT;
      ST_BL_WAIT: if (!want_on) state_d = ST_PWR_DN;
                  else if (tmr_expired) state_d = ST_ON;
      ST_ON:      if (!want_on) state_d = ST_BL_OFF;
      ST_BL_OFF:  if (tmr_expired) state_d = ST_PWR_DN;
      ST_PWR_DN:  if (tmr_expired) state_d = ST_CYCLE;
      ST_CYCLE:   if (tmr_expired) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    tmr_load = (state_d != state_q);
    tmr_long = (state_d == ST_CYCLE);
    case (state_d)
      ST_PWR_UP:  tmr_val = dly_up;
      ST_BL_WAIT: tmr_val = dly_blon;
      ST_BL_OFF:  tmr_val = dly_bloff;
      ST_PWR_DN:  tmr_val = dly_dn;
      ST_CYCLE:   tmr_val = cyc_units;
      default:    tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign seq_vdd    = (state_q == ST_PWR_UP) || (state_q == ST_BL_WAIT) ||
                      (state_q == ST_ON)     || (state_q == ST_BL_OFF);
  assign full_on    = (state_q == ST_ON);
  assign cyc_active = (state_q == ST_CYCLE);
  assign progress   = ((state_q == ST_PWR_UP) || (state_q == ST_BL_WAIT)) ? 2'b01 :
                      ((state_q == ST_BL_OFF) || (state_q == ST_PWR_DN))  ? 2'b10 : 2'b00;

  // R8: the minimum off time is never left before the timer expires
  p_cycle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CYCLE && !tmr_expired) |=> (state_q == ST_CYCLE));

  // R9: a dropped request during power-up goes straight to power-down
  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_PWR_UP || state_q == ST_BL_WAIT) && !want_on)
      |=> (state_q == ST_PWR_DN));

  // R7: the direction code never shows both bits
  p_progress_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(progress));
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import pps_pkg::*;
#(
  parameter int TICK_CLKS  = 10000,
  parameter int LONG_TICKS = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        vdd_en,
  output logic        bl_en
);
  logic on_req, bl_req, vdd_ovr;
  logic [DLY_W-1:0] dly_up, dly_blon, dly_dn, dly_bloff, tmr_val;
  logic [CYC_W-1:0] cyc_code;
  logic tmr_load, tmr_long, tmr_expired;
  logic seq_vdd, full_on, cyc_active;
  logic [1:0] progress;
  logic [31:0] stat_word;

  assign stat_word = {full_on, 1'b0, progress, cyc_active, 27'd0};

  pps_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .stat_word(stat_word),
    .bus_rdata(bus_rdata), .on_req(on_req), .bl_req(bl_req), .vdd_ovr(vdd_ovr),
    .dly_up(dly_up), .dly_blon(dly_blon), .dly_dn(dly_dn),
    .dly_bloff(dly_bloff), .cyc_code(cyc_code)
  );

  pps_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .want_on(on_req),
    .dly_up(dly_up), .dly_blon(dly_blon), .dly_dn(dly_dn),
    .dly_bloff(dly_bloff), .cyc_code(cyc_code), .tmr_expired(tmr_expired),
    .tmr_load(tmr_load), .tmr_long(tmr_long), .tmr_val(tmr_val),
    .seq_vdd(seq_vdd), .full_on(full_on), .progress(progress),
    .cyc_active(cyc_active)
  );

  pps_timer #(.TICK_CLKS(TICK_CLKS), .LONG_TICKS(LONG_TICKS), .CNT_W(DLY_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .long_unit(tmr_long),
    .load_val(tmr_val), .expired(tmr_expired)
  );

  assign vdd_en = seq_vdd || vdd_ovr;
  assign bl_en  = full_on && bl_req;

  // R5: the backlight never runs without panel supply
  p_bl_needs_vdd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bl_en |-> vdd_en);

  // R6: the backlight is already off in the cycle before the sequenced supply drops
  p_bl_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seq_vdd) |-> !$past(bl_en));
endmodule

// File: tb/panel_pwr_seq_bench.sv
`timescale 1ns/1ps
module panel_pwr_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        vdd_en, bl_en;

  int n_chk = 0;
  int n_bad = 0;
  int cyc_q = 0;
  bit done = 1'b0;

  localparam logic [31:0] KEY = 32'hABCD_0000;

  panel_pwr_seq #(.TICK_CLKS(4), .LONG_TICKS(5)) u_panel_pwr_seq (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .vdd_en(vdd_en), .bl_en(bl_en)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc_q <= cyc_q + 1;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, output int w);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    w = cyc_q;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_to(input int t);
    while (cyc_q < t) @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 vdd_en", {31'd0, vdd_en}, 32'd0);
    chk("R1 bl_en", {31'd0, bl_en}, 32'd0);
    rd(3'd1, d); chk("R1 status", d, 32'd0);
    rd(3'd2, d); chk("R1 on-delay", d, 32'h0834_01F4);
    rd(3'd3, d); chk("R1 off-delay", d, 32'h1388_01F4);
    rd(3'd4, d); chk("R1 cycle code", d, 32'd7);
    rd(3'd0, d); chk("R1 control", d, 32'd0);
  endtask

  task automatic t_fields();
    logic [31:0] d;
    int w;
    wr(3'd2, 32'hFFFF_FFFF, w); rd(3'd2, d); chk("R3 on-delay mask", d, 32'h1FFF_1FFF);
    wr(3'd2, 32'h0003_0002, w); rd(3'd2, d); chk("R3 on-delay", d, 32'h0003_0002);
    wr(3'd3, 32'h0003_0002, w); rd(3'd3, d); chk("R3 off-delay", d, 32'h0003_0002);
    wr(3'd4, 32'hFFFF_FFE3, w); rd(3'd4, d); chk("R3 cycle code", d, 32'd3);
  endtask

  task automatic t_key();
    logic [31:0] d;
    int w;
    wr(3'd0, 32'h0000_000F, w);
    wait_to(w + 5);
    rd(3'd0, d); chk("R2 no key control", d, 32'd0);
    chk("R2 no key vdd", {31'd0, vdd_en}, 32'd0);
    wr(3'd0, 32'h1234_0001, w);
    rd(3'd0, d); chk("R2 wrong key", d, 32'd0);
    wr(3'd0, KEY | 32'h2, w);
    rd(3'd0, d); chk("R2 flag stored", d, 32'd2);
    wr(3'd0, KEY, w);
    rd(3'd0, d); chk("R2 cleared", d, 32'd0);
  endtask

  task automatic t_power_up();
    logic [31:0] d;
    int w;
    wr(3'd0, KEY | 32'h5, w);
    wait_to(w + 2);
    chk("R4 vdd up", {31'd0, vdd_en}, 32'd1);
    rd(3'd1, d); chk("R7 progress up", d, 32'h1000_0000);
    wait_to(w + 21);
    chk("R4 backlight held", {31'd0, bl_en}, 32'd0);
    wait_to(w + 24);
    chk("R4 backlight on", {31'd0, bl_en}, 32'd1);
    rd(3'd1, d); chk("R7 fully on", d, 32'h8000_0000);
  endtask

  task automatic t_bl_gate();
    int w;
    wr(3'd0, KEY | 32'h1, w);
    wait_to(w + 1);
    chk("R5 backlight gated", {31'd0, bl_en}, 32'd0);
    chk("R5 vdd kept", {31'd0, vdd_en}, 32'd1);
    wr(3'd0, KEY | 32'h5, w);
    wait_to(w + 1);
    chk("R5 backlight back", {31'd0, bl_en}, 32'd1);
  endtask

  task automatic t_power_down_and_cycle();
    logic [31:0] d;
    int w, w2;
    wr(3'd0, KEY | 32'h4, w);
    wait_to(w + 2);
    chk("R6 backlight first", {31'd0, bl_en}, 32'd0);
    chk("R6 vdd still on", {31'd0, vdd_en}, 32'd1);
    rd(3'd1, d); chk("R7 progress down", d, 32'h2000_0000);
    wr(3'd0, KEY | 32'h5, w2);
    wait_to(w + 8);
    chk("R6 vdd before delay", {31'd0, vdd_en}, 32'd1);
    wait_to(w + 11);
    chk("R6 vdd off", {31'd0, vdd_en}, 32'd0);
    rd(3'd1, d); chk("R6 still busy", d, 32'h2000_0000);
    wait_to(w + 25);
    rd(3'd1, d); chk("R7 cycle active", d, 32'h0800_0000);
    wait_to(w + 62);
    chk("R8 request held", {31'd0, vdd_en}, 32'd0);
    rd(3'd1, d); chk("R8 cycle still active", d, 32'h0800_0000);
    wait_to(w + 67);
    chk("R8 power-up after cycle", {31'd0, vdd_en}, 32'd1);
    wait_to(w + 100);
    chk("R8 fully on again", {31'd0, bl_en}, 32'd1);
  endtask

  task automatic t_zero_cycle();
    int w, w2;
    wr(3'd4, 32'd1, w);
    wr(3'd0, KEY | 32'h4, w);
    wr(3'd0, KEY | 32'h5, w2);
    wait_to(w + 20);
    chk("R8 off before re-up", {31'd0, vdd_en}, 32'd0);
    wait_to(w + 27);
    chk("R8 zero cycle delay", {31'd0, vdd_en}, 32'd1);
    wr(3'd0, KEY, w);
    wait_to(w + 60);
  endtask

  task automatic t_abort();
    logic [31:0] d;
    int w, w2;
    wr(3'd0, KEY | 32'h5, w);
    wait_to(w + 3);
    wr(3'd0, KEY | 32'h4, w2);
    wait_to(w2 + 2);
    chk("R9 vdd aborted", {31'd0, vdd_en}, 32'd0);
    chk("R9 no backlight", {31'd0, bl_en}, 32'd0);
    rd(3'd1, d); chk("R9 progress down", d, 32'h2000_0000);
    wait_to(w2 + 40);
    rd(3'd1, d); chk("R9 back to idle", d, 32'd0);
  endtask

  task automatic t_override();
    logic [31:0] d;
    int w;
    wr(3'd0, KEY | 32'hC, w);
    wait_to(w + 1);
    chk("R10 forced vdd", {31'd0, vdd_en}, 32'd1);
    chk("R10 no backlight", {31'd0, bl_en}, 32'd0);
    rd(3'd1, d); chk("R10 status idle", d, 32'd0);
    wr(3'd0, KEY, w);
    wait_to(w + 1);
    chk("R10 release", {31'd0, vdd_en}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #2;
    t_reset();
    t_fields();
    t_key();
    t_power_up();
    t_bl_gate();
    t_power_down_and_cycle();
    t_zero_cycle();
    t_abort();
    t_override();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule